// File: doc/BRIEF.md
# SPI Serial Memory Command Slave

This block is the serial front end of a 2 KB byte-addressed memory. A host selects it by pulling chip select low. It clocks an 8-bit instruction in on SI, and then the address and data bytes the instruction needs. The block either streams memory or status bytes out on SO, or stores a byte and a protection level. The array is an internal register file. A busy counter of fixed length stands in for the cell programming time.

The pins SCK, chip select and SI are synchronised into the system clock `clk_i`. The bus runs in mode 0: the block samples SI on the rising edge of SCK and changes SO after the falling edge. The instruction decoder sends its enable, disable, write and status-write requests to a status and protection unit. That unit holds the write-enable latch, the two-bit protection level and the busy counter, and it grants or refuses each commit.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe_o` is 0. A status read right after reset returns 0x00.
- R2: READ (0x03) is followed by a high address byte and a low address byte. The high byte uses only bits 2:0 as A10..A8; its upper five bits are ignored. The byte at that address then appears on SO, most significant bit first, with SI don't-care.
- R3: While chip select stays low during a read, the address advances by one after each byte. It wraps from 0x7FF to 0x000, so one transaction can stream the whole array.
- R4: RDSR (0x05) returns a status byte after the opcode, and repeats it for every further byte. The fields are: bit 0 busy, bit 1 write enable, bits 3:2 protection level, bits 7:4 zero. While busy, the byte is 0xFF.
- R5: WREN (0x06) sets the write-enable latch. WRDI (0x04) clears it.
- R6: WRITE (0x02) has the same two-byte address form as READ. The write is committed when chip select rises after at least one complete data byte, and the last complete data byte is stored. A transaction that ends before a complete data byte stores nothing.
- R7: A WRITE or WRSR commit takes effect only when write enable is set. Otherwise memory and status are left unchanged.
- R8: The protection level denies writes to addresses 0x600..0x7FF (level 1), 0x400..0x7FF (level 2) or every address (level 3); level 0 denies none. A denied write changes neither memory nor the write-enable latch.
- R9: WRSR (0x01) with one data byte loads the protection level from data bits 3:2 when chip select rises.
- R10: An accepted commit clears write enable and holds busy for BUSY_CYCLES clock cycles.
- R11: While busy, every opcode except RDSR is ignored.
- R12: An unknown opcode makes the block ignore the rest of the transaction until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; SO is high-impedance when this is 0 |

## Verification
A commit lands on the chip-select rise. In that same cycle the status unit judges the grant against write enable, the protection level and the address, and then starts busy and clears write enable. The bench provokes a clash by sending a WREN, and separately an RDSR, right behind a commit while the busy count is still running. It expects the WREN to be dropped, so that write enable reads back 0 once busy ends, and the RDSR to return 0xFF. Denied writes are judged on two things: the memory contents are unchanged, and write enable still reads back as set.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_OP, PH_AHI, PH_ALO, PH_RD, PH_WD, PH_SR, PH_STAT, PH_IGN
  } phase_e;

  // top two address bits against the protection level
  function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return top == 2'b11;
      2'd2:    return top[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sel_o,
  output logic sel_end_o,
  output logic si_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_p, cs_p, si_p;
  logic sck_d, sel_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
      sck_d <= 1'b0;
      sel_d <= 1'b0;
    end else begin
      sck_p <= {sck_p[STAGES-2:0], sck_i};
      cs_p  <= {cs_p[STAGES-2:0], cs_ni};
      si_p  <= {si_p[STAGES-2:0], si_i};
      sck_d <= sck_p[TOP];
      sel_d <= ~cs_p[TOP];
    end
  end

  assign sck_rise_o = sck_p[TOP] & ~sck_d;
  assign sck_fall_o = ~sck_p[TOP] & sck_d;
  assign sel_o      = ~cs_p[TOP];
  assign sel_end_o  = sel_d & cs_p[TOP];
  assign si_o       = si_p[TOP];
endmodule

// File: rtl/spi_status_prot.sv
module spi_status_prot
  import spi_mem_pkg::*;
#(
  parameter int BUSY_CYCLES = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wen_set_i,
  input  logic       wen_clr_i,
  input  logic       wr_req_i,
  input  logic       sr_req_i,
  input  logic [7:0] sr_data_i,
  input  logic [1:0] addr_top_i,
  output logic       mem_we_o,
  output logic       sr_we_o,
  output logic       busy_o,
  output logic       wen_o,
  output logic [1:0] lvl_o,
  output logic [7:0] status_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign mem_we_o = wr_req_i & wen_o & ~busy_o & ~prot_hit(lvl_o, addr_top_i);
  assign sr_we_o  = sr_req_i & wen_o & ~busy_o;
  assign status_o = busy_o ? 8'hFF : {4'b0000, lvl_o, wen_o, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_o  <= 1'b0;
      lvl_o  <= 2'd0;
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (mem_we_o || sr_we_o) begin
      wen_o  <= 1'b0;
      busy_o <= 1'b1;
      cnt    <= CNT_W'(BUSY_CYCLES - 1);
      if (sr_we_o) lvl_o <= sr_data_i[3:2];
    end else begin
      if (busy_o) begin
        if (cnt == '0) busy_o <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
      if (wen_set_i)      wen_o <= 1'b1;
      else if (wen_clr_i) wen_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_byte_array.sv
module spi_byte_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int BUSY_CYCLES = 150,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int HI_W = ADDR_W - 8;

  logic sck_rise, sck_fall, sel, sel_end, si_s;
  logic mem_we, sr_we, busy, wen;
  logic [1:0] lvl;
  logic [7:0] status, rdata, byte_in, wdata, srdata, out_sh;
  logic [6:0] in_sh;
  logic [2:0] bit_cnt;
  logic [ADDR_W-1:0] addr, rd_addr;
  logic pend_wr, pend_sr, is_rd, so_q, byte_done;
  logic wen_set, wen_clr;
  phase_e ph;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .sel_o(sel), .sel_end_o(sel_end), .si_o(si_s)
  );

  assign byte_in   = {in_sh, si_s};
  assign byte_done = sel & sck_rise & (bit_cnt == 3'd7);
  assign rd_addr   = (ph == PH_ALO) ? {addr[ADDR_W-1:8], byte_in} : addr + 1'b1;
  assign wen_set   = byte_done & (ph == PH_OP) & ~busy & (byte_in == OP_WREN);
  assign wen_clr   = byte_done & (ph == PH_OP) & ~busy & (byte_in == OP_WRDI);

  spi_status_prot #(.BUSY_CYCLES(BUSY_CYCLES)) u_stat (
    .clk_i, .rst_ni,
    .wen_set_i(wen_set), .wen_clr_i(wen_clr),
    .wr_req_i(sel_end & pend_wr), .sr_req_i(sel_end & pend_sr),
    .sr_data_i(srdata), .addr_top_i(addr[ADDR_W-1 -: 2]),
    .mem_we_o(mem_we), .sr_we_o(sr_we), .busy_o(busy), .wen_o(wen),
    .lvl_o(lvl), .status_o(status)
  );

  spi_byte_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(addr), .wdata_i(wdata),
    .raddr_i(rd_addr), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph      <= PH_OP;
      bit_cnt <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
      so_q    <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      srdata  <= '0;
      pend_wr <= 1'b0;
      pend_sr <= 1'b0;
      is_rd   <= 1'b0;
    end else if (!sel) begin
      ph      <= PH_OP;
      bit_cnt <= '0;
      out_sh  <= '0;
      so_q    <= 1'b0;
      pend_wr <= 1'b0;
      pend_sr <= 1'b0;
    end else begin
      if (sck_fall) begin
        so_q   <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
      if (sck_rise) begin
        in_sh   <= byte_in[6:0];
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (byte_done) begin
        unique case (ph)
          PH_OP: begin
            if (busy && byte_in != OP_RDSR) ph <= PH_IGN;
            else begin
              unique case (byte_in)
                OP_READ:  begin ph <= PH_AHI; is_rd <= 1'b1; end
                OP_WRITE: begin ph <= PH_AHI; is_rd <= 1'b0; end
                OP_RDSR:  begin ph <= PH_STAT; out_sh <= status; end
                OP_WRSR:  ph <= PH_SR;
                default:  ph <= PH_IGN;
              endcase
            end
          end
          PH_AHI: begin
            addr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
            ph <= PH_ALO;
          end
          PH_ALO: begin
            addr[7:0] <= byte_in;
            if (is_rd) begin
              out_sh <= rdata;
              ph     <= PH_RD;
            end else ph <= PH_WD;
          end
          PH_RD: begin
            addr   <= rd_addr;
            out_sh <= rdata;
          end
          PH_WD: begin
            wdata   <= byte_in;
            pend_wr <= 1'b1;
          end
          PH_SR: begin
            srdata  <= byte_in;
            pend_sr <= 1'b1;
          end
          PH_STAT: out_sh <= status;
          default: ;
        endcase
      end
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = sel;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
  import spi_mem_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_we_i,
  input logic       sr_we_i,
  input logic       wen_i,
  input logic       busy_i,
  input logic [1:0] lvl_i,
  input logic [1:0] addr_top_i,
  input logic       sel_i
);
  p_commit_on_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i || sr_we_i) |-> (!sel_i && $past(sel_i)));

  p_wen_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i || sr_we_i) |-> $past(wen_i));

  p_level_respected_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !prot_hit(lvl_i, addr_top_i));

  p_busy_after_commit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i || sr_we_i) |=> (busy_i && !wen_i));

  p_no_commit_while_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i || sr_we_i) |-> !$past(busy_i));

  p_wen_static_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> !$rose(wen_i));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_we_i(mem_we), .sr_we_i(sr_we),
  .wen_i(wen), .busy_i(busy), .lvl_i(lvl),
  .addr_top_i(addr[ADDR_W-1 -: 2]), .sel_i(sel)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [2048];

  always #10 clk = ~clk;

  spi_mem_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(posedge clk);
      #1 rx[i] = so;
      sck = 1'b1;
      repeat (HALF) @(posedge clk);
      #1 sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic cs_off();
    repeat (HALF) @(posedge clk); #1 cs_n = 1'b1;
    repeat (4*HALF) @(posedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_on(); xfer(op, d); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_on(); xfer(8'h05, d); xfer(8'h00, st); cs_off();
  endtask

  task automatic wait_ready();
    logic [7:0] st;
    for (int k = 0; k < 20; k++) begin
      rdsr(st);
      if (!st[0]) return;
    end
  endtask

  task automatic write_raw(input int a, input logic [7:0] dv);
    logic [7:0] d;
    cs_on(); xfer(8'h02, d); xfer(8'(a >> 8), d); xfer(8'(a), d); xfer(dv, d); cs_off();
  endtask

  task automatic read1(input int a, input logic [7:0] junk, output logic [7:0] v);
    logic [7:0] d;
    cs_on(); xfer(8'h03, d); xfer(junk | 8'(a >> 8), d); xfer(8'(a), d); xfer(8'h00, v); cs_off();
  endtask

  function automatic bit denied(input int lvl, input int a);
    return (lvl == 1 && a >= 'h600) || (lvl == 2 && a >= 'h400) || lvl == 3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, v, d;
    int addrs [16];
    int pa [6];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk({7'b0, so_oe}, 8'h00, "R1 oe after reset");
    rdsr(st);
    chk(st, 8'h00, "R1 reset status");
    #1 chk({7'b0, so_oe}, 8'h00, "R1 oe with cs high");

    // R5 enable/disable
    cmd1(8'h06); rdsr(st); chk(st, 8'h02, "R5 wren");
    cmd1(8'h04); rdsr(st); chk(st, 8'h00, "R5 wrdi");

    // R4 repeated status bytes
    cmd1(8'h06);
    cs_on(); xfer(8'h05, d); xfer(8'h00, st); xfer(8'h00, v); cs_off();
    chk(st, 8'h02, "R4 status byte 1"); chk(v, 8'h02, "R4 status byte 2");
    cmd1(8'h04);

    // address sweep incl. wrap corners
    addrs[0] = 'h7FE; addrs[1] = 'h7FF; addrs[2] = 'h000; addrs[3] = 'h001;
    for (int i = 4; i < 16; i++) addrs[i] = (i * 'h0A3 + 'h155) & 'h7FF;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] dv;
      dv = 8'((addrs[i] * 7 + 3) ^ i);
      cmd1(8'h06);
      write_raw(addrs[i], dv);
      model[addrs[i]] = dv;
      if (i == 0) begin
        rdsr(st); chk(st, 8'hFF, "R4 busy status");
      end else if (i == 1) begin
        cmd1(8'h06);  // R11 WREN during busy must be dropped
      end
      wait_ready();
      rdsr(st);
      chk(st, 8'h00, i == 1 ? "R11 wren ignored while busy" : "R10 wen cleared after commit");
    end
    for (int i = 0; i < 16; i++) begin
      read1(addrs[i], (i % 2) ? 8'hF8 : 8'h00, v);
      chk(v, model[addrs[i]], "R2 read back");
    end

    // R3 streaming with wrap
    cs_on(); xfer(8'h03, d); xfer(8'h07, d); xfer(8'hFE, d);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h5A, v);
      chk(v, model[('h7FE + i) & 'h7FF], "R3 stream wrap");
    end
    cs_off();

    // R7 write without enable
    write_raw('h000, 8'hC3);
    read1('h000, 8'h00, v); chk(v, model[0], "R7 no wen no write");

    // R6 multi-byte keeps last, incomplete discarded
    cmd1(8'h06);
    cs_on(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h01, d); xfer(8'h11, d); xfer(8'h22, d); cs_off();
    model[1] = 8'h22; wait_ready();
    read1('h001, 8'h00, v); chk(v, 8'h22, "R6 last byte stored");
    cmd1(8'h06);
    cs_on(); xfer(8'h02, d); xfer(8'h07, d); xfer(8'hFF, d); cs_off();
    rdsr(st); chk(st, 8'h02, "R6 incomplete no commit");
    read1('h7FF, 8'h00, v); chk(v, model['h7FF], "R6 incomplete memory");

    // R12 unknown opcode swallows rest
    cs_on(); xfer(8'h9C, d); xfer(8'h02, d); xfer(8'h07, d); xfer(8'hFF, d); xfer(8'h00, d); cs_off();
    rdsr(st); chk(st, 8'h02, "R12 unknown opcode status");
    read1('h7FF, 8'h00, v); chk(v, model['h7FF], "R12 unknown opcode memory");
    cmd1(8'h04);

    // R9 WRSR without enable
    cs_on(); xfer(8'h01, d); xfer(8'h0C, d); cs_off();
    rdsr(st); chk(st, 8'h00, "R9 wrsr needs wen");

    // R8 protection levels
    pa[0] = 'h000; pa[1] = 'h3FF; pa[2] = 'h400; pa[3] = 'h5FF; pa[4] = 'h600; pa[5] = 'h7FF;
    for (int lvl = 0; lvl < 4; lvl++) begin
      cmd1(8'h06);
      cs_on(); xfer(8'h01, d); xfer(8'(lvl << 2), d); cs_off();
      wait_ready();
      rdsr(st); chk(st, 8'(lvl << 2), "R9 level loaded");
      for (int j = 0; j < 6; j++) begin
        logic [7:0] dv;
        dv = 8'(lvl * 16 + j + 8'h40);
        cmd1(8'h06);
        write_raw(pa[j], dv);
        if (denied(lvl, pa[j])) begin
          rdsr(st); chk(st, 8'((lvl << 2) | 2), "R8 denied keeps wen");
          cmd1(8'h04);
        end else begin
          model[pa[j]] = dv;
          wait_ready();
        end
        read1(pa[j], 8'h00, v); chk(v, model[pa[j]], "R8 protected region");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule